// File: doc/BRIEF.md
# Fault Routing and Escalation Unit

This block sits beside a processor pipeline and turns raw fault event pulses into handler requests. Every fault cause is tied to one of three handlers (hard, bus or usage) and to one sticky bit in that handler's status register. A bus or usage fault normally goes to its own handler. It is promoted to the hard handler when that handler is switched off, when that handler is already running, or when its configured priority does not beat the current execution priority. Hard requests win over bus requests, and bus requests win over usage requests.

Software reads the three status registers and clears bits by writing ones to a clear mask. The handler request leaves the block as a registered single-cycle pulse carrying a vector number. Priorities are encoded so that a numerically smaller value means a more urgent level.

Top module: `fault_route_unit`

## Requirements
- R1: A vector-table read error (`vec_err`) gives a request with vector 3 in the next cycle and sets hard status bit 0.
- R2: Bus cause bit i of `bus_evt` sets `bus_stat[i]` in the next cycle. Bit order: 0 stacking, 1 unstacking, 2 instruction fetch, 3 precise data, 4 imprecise data.
- R3: Usage cause bit i of `use_evt` sets `use_stat[i]` in the next cycle. Bit order: 0 coprocessor, 1 undefined instruction, 2 invalid state, 3 invalid return value, 4 unaligned access, 5 divide by zero.
- R4: A bus fault while `bus_en` is 0, or a usage fault while `use_en` is 0, is routed to the hard handler (vector 3).
- R5: A bus fault while `act_hdl[0]` is 1, or a usage fault while `act_hdl[1]` is 1, is routed to the hard handler.
- R6: A bus or usage fault whose configured priority is numerically greater than or equal to `cur_prio` is routed to the hard handler. Smaller values are more urgent.
- R7: Any escalation sets hard status bit 1 (forced), and the original cause bit is also set in its own register.
- R8: Status bits stay set until a 1 is written to the matching bit of the clear mask. A new fault on a bit in the same cycle as its clear leaves the bit set.
- R9: When several faults arrive in one cycle, one request is issued: hard before bus before usage. The vector is 3, 5 or 6 respectively.
- R10: A request is a pulse registered one cycle after its fault event. A cycle with no fault event gives no request in the following cycle.
- R11: After reset, all status bits are 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_err | input | 1 | Bus error on vector table read |
| bus_evt | input | 5 | Bus fault cause pulses |
| use_evt | input | 6 | Usage fault cause pulses |
| bus_en | input | 1 | Bus handler enabled |
| use_en | input | 1 | Usage handler enabled |
| bus_prio | input | PW | Configured bus handler priority |
| use_prio | input | PW | Configured usage handler priority |
| cur_prio | input | PW | Current execution priority |
| act_hdl | input | 2 | Active handler: bit 0 bus, bit 1 usage |
| clr_hard | input | 2 | Write-1-to-clear mask for hard status |
| clr_bus | input | 5 | Write-1-to-clear mask for bus status |
| clr_use | input | 6 | Write-1-to-clear mask for usage status |
| req | output | 1 | Handler request pulse |
| req_id | output | 3 | Vector number of the request |
| hard_stat | output | 2 | Hard status: bit 0 vector read, bit 1 forced |
| bus_stat | output | 5 | Bus status bits |
| use_stat | output | 6 | Usage status bits |

## Verification
The hardest situation to reach is a bus fault and a usage fault in the same cycle, where one escalates and the other does not. The hard request must then win, the forced bit must be set, and both cause bits must still land. Random stimulus draws enables, active flags and priorities independently of each other and fires each fault class with moderate probability, so mixed cases occur often. Directed steps cover the equal-priority edge and a set that coincides with its own clear.

// File: rtl/fault_route_pkg.sv
package fault_route_pkg;
  localparam int BUS_N  = 5;
  localparam int USE_N  = 6;
  localparam int HARD_N = 2;
  localparam int VID_W  = 3;

  localparam logic [VID_W-1:0] VID_HARD = 3'd3;
  localparam logic [VID_W-1:0] VID_BUS  = 3'd5;
  localparam logic [VID_W-1:0] VID_USE  = 3'd6;

  localparam int HARD_VEC_BIT    = 0;
  localparam int HARD_FORCED_BIT = 1;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HARD = 2'd1,
    SRC_BUS  = 2'd2,
    SRC_USE  = 2'd3
  } fault_src_e;

  function automatic fault_src_e pick_source(input logic hard_raise,
                                             input logic bus_take,
                                             input logic use_take);
    if (hard_raise)    return SRC_HARD;
    else if (bus_take) return SRC_BUS;
    else if (use_take) return SRC_USE;
    return SRC_NONE;
  endfunction

  function automatic logic [VID_W-1:0] source_vector(input fault_src_e s);
    case (s)
      SRC_HARD: return VID_HARD;
      SRC_BUS:  return VID_BUS;
      SRC_USE:  return VID_USE;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/fault_class_esc.sv
module fault_class_esc #(
  parameter int N  = 5,
  parameter int PW = 3
) (
  input  logic [N-1:0]  evt,
  input  logic          en,
  input  logic          active,
  input  logic [PW-1:0] cfg_prio,
  input  logic [PW-1:0] cur_prio,
  output logic          any,
  output logic          esc,
  output logic          take
);
  // Smaller number means more urgent; equal does not preempt.
  function automatic logic cannot_take(input logic e, input logic a,
                                       input logic [PW-1:0] p,
                                       input logic [PW-1:0] c);
    return !e || a || (p >= c);
  endfunction

  always_comb begin
    any  = |evt;
    esc  = any && cannot_take(en, active, cfg_prio, cur_prio);
    take = any && !esc;
  end
endmodule

// File: rtl/fault_w1c_reg.sv
module fault_w1c_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/fault_req_arb.sv
module fault_req_arb
  import fault_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_raise,
  input  logic             bus_take,
  input  logic             use_take,
  output logic             req,
  output logic [VID_W-1:0] req_id
);
  fault_src_e win;

  always_comb win = pick_source(hard_raise, bus_take, use_take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      req_id <= '0;
    end else begin
      req    <= (win != SRC_NONE);
      req_id <= source_vector(win);
    end
  end
endmodule

// File: rtl/fault_route_unit.sv
module fault_route_unit
  import fault_route_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_err,
  input  logic [BUS_N-1:0]  bus_evt,
  input  logic [USE_N-1:0]  use_evt,
  input  logic              bus_en,
  input  logic              use_en,
  input  logic [PW-1:0]     bus_prio,
  input  logic [PW-1:0]     use_prio,
  input  logic [PW-1:0]     cur_prio,
  input  logic [1:0]        act_hdl,
  input  logic [HARD_N-1:0] clr_hard,
  input  logic [BUS_N-1:0]  clr_bus,
  input  logic [USE_N-1:0]  clr_use,
  output logic              req,
  output logic [VID_W-1:0]  req_id,
  output logic [HARD_N-1:0] hard_stat,
  output logic [BUS_N-1:0]  bus_stat,
  output logic [USE_N-1:0]  use_stat
);
  logic bus_any, bus_esc, bus_take;
  logic use_any, use_esc, use_take;
  logic forced_evt, hard_raise;
  logic [HARD_N-1:0] hard_set;

  fault_class_esc #(.N(BUS_N), .PW(PW)) u_bus_esc (
    .evt(bus_evt), .en(bus_en), .active(act_hdl[0]),
    .cfg_prio(bus_prio), .cur_prio(cur_prio),
    .any(bus_any), .esc(bus_esc), .take(bus_take)
  );

  fault_class_esc #(.N(USE_N), .PW(PW)) u_use_esc (
    .evt(use_evt), .en(use_en), .active(act_hdl[1]),
    .cfg_prio(use_prio), .cur_prio(cur_prio),
    .any(use_any), .esc(use_esc), .take(use_take)
  );

  always_comb begin
    forced_evt = bus_esc || use_esc;
    hard_raise = vec_err || forced_evt;
    hard_set   = '0;
    hard_set[HARD_VEC_BIT]    = vec_err;
    hard_set[HARD_FORCED_BIT] = forced_evt;
  end

  fault_w1c_reg #(.W(HARD_N)) u_hard_reg (
    .clk(clk), .rst_n(rst_n), .set(hard_set), .clr(clr_hard), .q(hard_stat)
  );
  fault_w1c_reg #(.W(BUS_N)) u_bus_reg (
    .clk(clk), .rst_n(rst_n), .set(bus_evt), .clr(clr_bus), .q(bus_stat)
  );
  fault_w1c_reg #(.W(USE_N)) u_use_reg (
    .clk(clk), .rst_n(rst_n), .set(use_evt), .clr(clr_use), .q(use_stat)
  );

  fault_req_arb u_arb (
    .clk(clk), .rst_n(rst_n), .hard_raise(hard_raise),
    .bus_take(bus_take), .use_take(use_take),
    .req(req), .req_id(req_id)
  );
endmodule

// File: rtl/fault_route_chk.sv
module fault_route_chk
  import fault_route_pkg::*;
#(
  parameter int PW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_err,
  input logic [BUS_N-1:0]  bus_evt,
  input logic [USE_N-1:0]  use_evt,
  input logic              bus_en,
  input logic              use_en,
  input logic [PW-1:0]     bus_prio,
  input logic [PW-1:0]     use_prio,
  input logic [PW-1:0]     cur_prio,
  input logic [1:0]        act_hdl,
  input logic [HARD_N-1:0] clr_hard,
  input logic [BUS_N-1:0]  clr_bus,
  input logic [USE_N-1:0]  clr_use,
  input logic              req,
  input logic [VID_W-1:0]  req_id,
  input logic [HARD_N-1:0] hard_stat,
  input logic [BUS_N-1:0]  bus_stat,
  input logic [USE_N-1:0]  use_stat
);
  p_vect_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |=> (req && req_id == VID_HARD && hard_stat[HARD_VEC_BIT]));

  p_bus_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_evt != '0) |=> ((bus_stat & $past(bus_evt)) == $past(bus_evt)));

  p_use_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_evt != '0) |=> ((use_stat & $past(use_evt)) == $past(use_evt)));

  p_bus_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_evt != '0) && !bus_en) |=> (req && req_id == VID_HARD));

  p_use_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((use_evt != '0) && act_hdl[1]) |=> (req && req_id == VID_HARD));

  p_bus_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_evt != '0) && (bus_prio >= cur_prio)) |=> (req && req_id == VID_HARD));

  p_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((use_evt != '0) && !use_en) |=> hard_stat[HARD_FORCED_BIT]);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bus != '0) |=> ((bus_stat & $past(clr_bus & ~bus_evt)) == '0));

  p_vector_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (req_id == VID_HARD || req_id == VID_BUS || req_id == VID_USE));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_err && bus_evt == '0 && use_evt == '0) |=> !req);
endmodule

bind fault_route_unit fault_route_chk #(.PW(PW)) chk_i (.*);

// File: tb/fault_route_unit_tb.sv
module fault_route_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_err = 1'b0;
  logic [4:0] bus_evt = '0;
  logic [5:0] use_evt = '0;
  logic bus_en = 1'b1, use_en = 1'b1;
  logic [PW-1:0] bus_prio = '0, use_prio = '0, cur_prio = '1;
  logic [1:0] act_hdl = '0;
  logic [1:0] clr_hard = '0;
  logic [4:0] clr_bus = '0;
  logic [5:0] clr_use = '0;
  logic req;
  logic [2:0] req_id;
  logic [1:0] hard_stat;
  logic [4:0] bus_stat;
  logic [5:0] use_stat;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [1:0] m_hard = '0;
  logic [4:0] m_bus = '0;
  logic [5:0] m_use = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_route_unit #(.PW(PW)) dut_i (.*);

  function automatic bit promoted(bit fired, bit en, bit act,
                                  logic [PW-1:0] p, logic [PW-1:0] c);
    if (!fired) return 0;
    return (en == 0) || act || !(p < c);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    vec_err = 0; bus_evt = '0; use_evt = '0;
    clr_hard = '0; clr_bus = '0; clr_use = '0;
    act_hdl = '0; bus_en = 1; use_en = 1;
    bus_prio = 3'd1; use_prio = 3'd2; cur_prio = 3'd6;
  endtask

  // Inputs are already driven; predict, clock, compare, go idle.
  task automatic step(string tag);
    bit be, ue, hr, bt, ut, e_req;
    int e_id;
    be = promoted(bus_evt != 0, bus_en, act_hdl[0], bus_prio, cur_prio);
    ue = promoted(use_evt != 0, use_en, act_hdl[1], use_prio, cur_prio);
    hr = vec_err || be || ue;
    bt = (bus_evt != 0) && !be;
    ut = (use_evt != 0) && !ue;
    e_req = hr || bt || ut;
    e_id = hr ? 3 : (bt ? 5 : (ut ? 6 : 0));
    m_hard = (m_hard & ~clr_hard) | {(be || ue), vec_err};
    m_bus  = (m_bus & ~clr_bus) | bus_evt;
    m_use  = (m_use & ~clr_use) | use_evt;
    @(posedge clk); #1;
    check(req == e_req, tag, "req", req, e_req);
    if (e_req) check(req_id == e_id[2:0], tag, "req_id", req_id, e_id);
    check(hard_stat == m_hard, tag, "hard_stat", hard_stat, m_hard);
    check(bus_stat == m_bus, tag, "bus_stat", bus_stat, m_bus);
    check(use_stat == m_use, tag, "use_stat", use_stat, m_use);
    idle();
  endtask

  initial begin
    void'($urandom(32'd7719));
    idle();
    repeat (3) @(posedge clk);
    #1;
    check(req == 0, "R11", "req", req, 0);
    check(hard_stat == 0 && bus_stat == 0 && use_stat == 0, "R11", "stat",
          {hard_stat, bus_stat, use_stat}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    step("R10");
    vec_err = 1;                          step("R1");
    bus_evt = 5'b01000;                   step("R2");
    use_evt = 6'b100000;                  step("R3");
    clr_hard = '1; clr_bus = '1; clr_use = '1; step("R8");
    bus_evt = 5'b00001; bus_en = 0;       step("R4");
    use_evt = 6'b000010; use_en = 0;      step("R7");
    use_evt = 6'b010000; act_hdl = 2'b10; step("R5");
    bus_evt = 5'b00100; act_hdl = 2'b01;  step("R5");
    bus_evt = 5'b10000; bus_prio = 3'd4; cur_prio = 3'd4; step("R6");
    use_evt = 6'b000100; use_prio = 3'd3; cur_prio = 3'd4; step("R6");
    bus_evt = 5'b00010; clr_bus = 5'b00010; step("R8");
    clr_bus = 5'b00010;                   step("R8");
    bus_evt = 5'b00010; use_evt = 6'b000001; step("R9");
    vec_err = 1; bus_evt = 5'b00001;      step("R9");
    bus_evt = 5'b00001; use_evt = 6'b000001; use_en = 0; step("R9");
    step("R10");
    for (int i = 0; i < 400; i++) begin
      vec_err  = ($urandom % 8) == 0;
      bus_evt  = (($urandom % 3) == 0) ? 5'($urandom) : '0;
      use_evt  = (($urandom % 3) == 0) ? 6'($urandom) : '0;
      bus_en   = $urandom % 4 != 0;
      use_en   = $urandom % 4 != 0;
      act_hdl  = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      bus_prio = PW'($urandom);
      use_prio = PW'($urandom);
      cur_prio = PW'($urandom);
      clr_hard = (($urandom % 5) == 0) ? 2'($urandom) : '0;
      clr_bus  = (($urandom % 5) == 0) ? 5'($urandom) : '0;
      clr_use  = (($urandom % 5) == 0) ? 6'($urandom) : '0;
      step("R9");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule